// File: doc/BRIEF.md
# Receive Message Queue with Overrun Lock

This block holds up to three accepted network frames for software. An upstream stage has already checked each frame for protocol errors and matched its identifier. It hands the frame over as a single-cycle valid pulse with a message word. The oldest held frame always sits on the mailbox output. Software reads it there and then pulses a release strobe to drop it. The next oldest frame then moves into the mailbox.

Occupancy runs through five states: empty, one, two or three frames held, and overrun. A 2-bit pending count and a sticky overrun flag make the state visible. When a fourth frame arrives and no release comes with it, the queue locks. The three stored frames stay as they are, later arrivals are thrown away, and the overrun flag is raised. Only a dedicated clear strobe lowers the flag. All state changes happen on one clock, and reset is active-low.

Top module: `rx_msg_queue`

## Requirements
- R1: After reset the pending count is 00 and the overrun flag is 0.
- R2: A valid pulse with no release raises the count by one, encoded 00, 01, 10 and 11 for zero to three held frames, while fewer than three frames are held.
- R3: Whenever the count is non-zero, the mailbox shows the oldest held frame, and frames leave in arrival order.
- R4: A release with no valid pulse and a non-zero count lowers the count by one and shows the next oldest frame on the next cycle.
- R5: A release and a valid pulse in the same cycle at count 01 keep the count at 01, and the new frame appears in the mailbox.
- R6: A valid pulse at count 11 with no release sets the overrun flag and leaves the count at 11.
- R7: While locked in overrun, valid pulses are discarded: the count stays 11 and the three stored frames come out unchanged and in order.
- R8: The overrun flag stays set until a clear strobe. If a frame is discarded in the same cycle as the clear, the flag stays set.
- R9: A release in the overrun state moves the count to 10 and shows the second stored frame. The overrun flag is not changed by this release.
- R10: A release at count 00 is ignored. The count stays 00, and the next accepted frame is the one shown in the mailbox.
- R11: A release and a valid pulse in the same cycle at count 10 or 11 keep the count unchanged, set no overrun, and queue the new frame behind the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid_i | input | 1 | One-cycle pulse: an accepted frame is on msg_data_i |
| msg_data_i | input | MSG_W | Frame word to store |
| release_i | input | 1 | Software strobe that drops the mailbox frame |
| ovr_clr_i | input | 1 | Strobe that clears the overrun flag |
| mbox_data_o | output | MSG_W | Oldest held frame (don't-care at count 00) |
| pending_o | output | 2 | Number of held frames |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bound checker tests the occupancy arithmetic on every cycle. It checks that the count goes up, goes down or holds as the valid and release inputs require, that the flag is set and stays set, and that the mailbox does not move while the queue is locked. Frame ordering through the circular slots can only be shown by the directed scenarios. The same holds for losing frames in the locked state, and for the mailbox content after a release with the queue empty. Those scenarios push known words and compare the sequence that comes out.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int SLOTS = 3;
  localparam int IDX_W = 2;
  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    OCC_EMPTY = 3'd0,
    OCC_ONE   = 3'd1,
    OCC_TWO   = 3'd2,
    OCC_THREE = 3'd3,
    OCC_LOCK  = 3'd4
  } occ_t;

  function automatic logic [CNT_W-1:0] occ_count(input occ_t s);
    case (s)
      OCC_EMPTY: occ_count = 2'b00;
      OCC_ONE:   occ_count = 2'b01;
      OCC_TWO:   occ_count = 2'b10;
      default:   occ_count = 2'b11;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] slot_next(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(SLOTS - 1)) slot_next = '0;
    else                          slot_next = idx + 1'b1;
  endfunction
endpackage

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             release_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             discard_o,
  output logic             lock_o,
  output logic [CNT_W-1:0] count_o
);
  occ_t state_q, state_d;

  always_comb begin
    pop_o     = release_i && (state_q != OCC_EMPTY);
    push_o    = valid_i && (state_q != OCC_LOCK) &&
                ((state_q != OCC_THREE) || release_i);
    discard_o = valid_i && !push_o;
    state_d   = state_q;
    case (state_q)
      OCC_EMPTY: if (push_o) state_d = OCC_ONE;
      OCC_ONE:
        if (push_o && !pop_o)      state_d = OCC_TWO;
        else if (pop_o && !push_o) state_d = OCC_EMPTY;
      OCC_TWO:
        if (push_o && !pop_o)      state_d = OCC_THREE;
        else if (pop_o && !push_o) state_d = OCC_ONE;
      OCC_THREE:
        if (discard_o)             state_d = OCC_LOCK;
        else if (pop_o && !push_o) state_d = OCC_TWO;
      OCC_LOCK:  if (pop_o) state_d = OCC_TWO;
      default:   state_d = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= OCC_EMPTY;
    else        state_q <= state_d;
  end

  assign lock_o  = (state_q == OCC_LOCK);
  assign count_o = occ_count(state_q);
endmodule

// File: rtl/rxq_slots.sv
module rxq_slots
  import rxq_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [MSG_W-1:0] data_i,
  output logic [MSG_W-1:0] head_o
);
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [MSG_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= slot_next(wr_q);
      if (pop_i)  rd_q <= slot_next(rd_q);
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic wr_hit;
    assign wr_hit = push_i && (wr_q == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (wr_hit) slot_q[i] <= data_i;
    end
  end

  assign head_o = slot_q[rd_q];
endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic discard_i,
  input  logic clear_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_o <= 1'b0;
    else if (discard_i) flag_o <= 1'b1;
    else if (clear_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/rx_msg_queue.sv
module rx_msg_queue
  import rxq_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid_i,
  input  logic [MSG_W-1:0] msg_data_i,
  input  logic             release_i,
  input  logic             ovr_clr_i,
  output logic [MSG_W-1:0] mbox_data_o,
  output logic [1:0]       pending_o,
  output logic             overrun_o
);
  logic push_w, pop_w, discard_w, lock_w;

  rxq_occupancy u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (msg_valid_i),
    .release_i (release_i),
    .push_o    (push_w),
    .pop_o     (pop_w),
    .discard_o (discard_w),
    .lock_o    (lock_w),
    .count_o   (pending_o)
  );

  rxq_slots #(.MSG_W(MSG_W)) u_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_w),
    .pop_i  (pop_w),
    .data_i (msg_data_i),
    .head_o (mbox_data_o)
  );

  rxq_ovr_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .discard_i (discard_w),
    .clear_i   (ovr_clr_i),
    .flag_o    (overrun_o)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int MSG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid_i,
  input logic             release_i,
  input logic             ovr_clr_i,
  input logic [MSG_W-1:0] mbox_data_o,
  input logic [1:0]       pending_o,
  input logic             overrun_o,
  input logic             lock_w,
  input logic             discard_w
);
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_i && !release_i && pending_o != 2'b11 |=> pending_o == $past(pending_o) + 2'd1); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    release_i && !msg_valid_i && pending_o != 2'b00 |=> pending_o == $past(pending_o) - 2'd1); // R4
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    release_i && msg_valid_i && !lock_w && pending_o != 2'b00 |=> pending_o == $past(pending_o)); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_i && !release_i && pending_o == 2'b11 |=> overrun_o && pending_o == 2'b11); // R6
  AST_LOCK_MBOX: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w && !release_i |=> $stable(mbox_data_o) && pending_o == 2'b11); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !ovr_clr_i |=> overrun_o); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr_i && !discard_w |=> !overrun_o); // R8
  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w && release_i |=> pending_o == 2'b10 && !lock_w); // R9
  AST_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o == 2'b00 && release_i && !msg_valid_i |=> pending_o == 2'b00); // R10
endmodule

bind rx_msg_queue rxq_checker #(.MSG_W(MSG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid_i (msg_valid_i),
  .release_i   (release_i),
  .ovr_clr_i   (ovr_clr_i),
  .mbox_data_o (mbox_data_o),
  .pending_o   (pending_o),
  .overrun_o   (overrun_o),
  .lock_w      (lock_w),
  .discard_w   (discard_w)
);

// File: tb/tb_rx_msg_queue.sv
module tb_rx_msg_queue;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, rel = 1'b0, clr = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] mbox;
  logic [1:0] pend;
  logic ovr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_msg_queue #(.MSG_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .msg_valid_i(vld), .msg_data_i(din),
    .release_i(rel), .ovr_clr_i(clr), .mbox_data_o(mbox),
    .pending_o(pend), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at posedge+2, outputs are read back at posedge+2 afterwards
  task automatic cyc(input logic v, input logic [W-1:0] d, input logic r, input logic c);
    vld = v; din = d; rel = r; clr = c;
    @(posedge clk); #2;
    vld = 1'b0; rel = 1'b0; clr = 1'b0; din = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", W'(pend), 0);
    chk("R1 flag", W'(ovr), 0);
  endtask

  task automatic t_fill_drain();
    do_reset();
    cyc(1, 32'hA1, 0, 0); chk("R2 count1", W'(pend), 1); chk("R3 head", mbox, 32'hA1);
    cyc(1, 32'hA2, 0, 0); chk("R2 count2", W'(pend), 2); chk("R3 head kept", mbox, 32'hA1);
    cyc(1, 32'hA3, 0, 0); chk("R2 count3", W'(pend), 3);
    cyc(0, 0, 1, 0); chk("R4 dec", W'(pend), 2); chk("R4 next", mbox, 32'hA2);
    cyc(0, 0, 1, 0); chk("R4 next2", mbox, 32'hA3); chk("R4 dec1", W'(pend), 1);
    cyc(0, 0, 1, 0); chk("R4 empty", W'(pend), 0); chk("R6 no ovr", W'(ovr), 0);
  endtask

  task automatic t_simul();
    do_reset();
    cyc(1, 32'hB1, 0, 0);
    cyc(1, 32'hB2, 1, 0); chk("R5 count", W'(pend), 1); chk("R5 mbox", mbox, 32'hB2);
    cyc(1, 32'hB3, 0, 0);
    cyc(1, 32'hB4, 1, 0); chk("R11 count2", W'(pend), 2); chk("R11 head", mbox, 32'hB3);
    cyc(1, 32'hB5, 0, 0);
    cyc(1, 32'hB6, 1, 0); chk("R11 count3", W'(pend), 3); chk("R11 no ovr", W'(ovr), 0);
    chk("R11 head3", mbox, 32'hB4);
    cyc(0, 0, 1, 0); chk("R11 order1", mbox, 32'hB5);
    cyc(0, 0, 1, 0); chk("R11 order2", mbox, 32'hB6);
  endtask

  task automatic t_overrun();
    do_reset();
    cyc(1, 32'hC1, 0, 0); cyc(1, 32'hC2, 0, 0); cyc(1, 32'hC3, 0, 0);
    cyc(1, 32'hC4, 0, 0); chk("R6 flag", W'(ovr), 1); chk("R6 count", W'(pend), 3);
    cyc(1, 32'hC5, 0, 0); chk("R7 count", W'(pend), 3); chk("R7 head", mbox, 32'hC1);
    cyc(0, 0, 0, 0); chk("R8 sticky", W'(ovr), 1);
    cyc(1, 32'hC6, 1, 0); chk("R9 count", W'(pend), 2); chk("R9 head", mbox, 32'hC2);
    chk("R9 flag kept", W'(ovr), 1);
    cyc(0, 0, 1, 0); chk("R7 kept C3", mbox, 32'hC3); chk("R7 count1", W'(pend), 1);
    cyc(0, 0, 1, 0); chk("R7 lost frames", W'(pend), 0);
    cyc(0, 0, 0, 1); chk("R8 clear", W'(ovr), 0);
    cyc(1, 32'hD1, 0, 0); cyc(1, 32'hD2, 0, 0); cyc(1, 32'hD3, 0, 0);
    cyc(1, 32'hD4, 0, 1); chk("R8 set beats clear", W'(ovr), 1);
    cyc(0, 0, 0, 1); chk("R8 clear again", W'(ovr), 0); chk("R7 still locked", W'(pend), 3);
  endtask

  task automatic t_empty_release();
    do_reset();
    cyc(0, 0, 1, 0); chk("R10 count", W'(pend), 0);
    cyc(0, 0, 1, 0); chk("R10 count again", W'(pend), 0);
    cyc(1, 32'hE1, 0, 0); chk("R10 head", mbox, 32'hE1); chk("R10 count1", W'(pend), 1);
    cyc(1, 32'hE2, 0, 0);
    cyc(0, 0, 1, 0); chk("R10 order", mbox, 32'hE2);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_fill_drain();
    t_simul();
    t_overrun();
    t_empty_release();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule